// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of `WIDTH` bits using one full-adder cell and one bit of storage for the carry, taking one clock per bit. Operand A and operand B sit in two right-shifting registers. On every enabled clock the cell adds the low bit of each register and the stored carry. The new sum bit enters the top of the A register, and both registers move one place toward the low end. After `WIDTH` enabled clocks, the A register holds the sum and the carry bit holds the carry out of the top bit.

A single-cycle `load` pulse starts an addition. It writes both operands in parallel, clears the carry and restarts the step counter. `shift_en` gates every step, so the surrounding logic can pause the addition at any cycle. While B is emptied through its low end, a bit stream on `b_ser_in` fills it from the top. A new operand can therefore be prepared during the current addition. Once `WIDTH` steps are done, the block raises `done` and freezes its state until the next load.

Top module: `bitser_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the A register, the B register, the carry and `done` all become 0.
- R2: A clock edge with `load` high writes `opa_in` into A and `opb_in` into B, clears the carry and `done`, and restarts the step count. This holds even if `shift_en` is also high; `load` takes priority.
- R3: On each enabled step, bit `WIDTH-1` of A receives A[0] xor B[0] xor carry, and the other bits of A move down one place. The carry takes the majority of those three bits. After k steps, the top k bits of A are the low k bits of the sum and the low bits are the original A shifted right by k.
- R4: On each enabled step, B moves down one place and bit `WIDTH-1` of B takes `b_ser_in`.
- R5: An edge with `shift_en` low and `load` low leaves A, B, the carry and `done` unchanged.
- R6: After exactly `WIDTH` enabled steps since a load, `sum_out` equals (A + B) mod 2^`WIDTH`, `carry_out` equals bit `WIDTH` of A + B, and `done` is 1.
- R7: While `done` is 1 and `load` is low, A, B, the carry and `done` do not change, even with `shift_en` high.
- R8: If bit j of a word is presented on `b_ser_in` at the j-th enabled step (j counted from 0), `b_out` equals that word once `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Start pulse: parallel load of both operands |
| shift_en | input | 1 | Enables one addition step per clock |
| opa_in | input | WIDTH | Operand A for parallel load |
| opb_in | input | WIDTH | Operand B for parallel load |
| b_ser_in | input | 1 | Serial bit entering the top of register B |
| sum_out | output | WIDTH | Contents of register A (the sum when done) |
| b_out | output | WIDTH | Contents of register B |
| carry_out | output | 1 | Stored carry bit |
| done | output | 1 | High once WIDTH steps have completed since the last load |

## Verification
The embedded assertions assume that `rst_n`, `load` and `shift_en` are known at every clock edge. They also assume that operands are sampled only at a load, so any value on `opa_in` and `opb_in` is legal. The bench drives every input on the falling edge, so the values are stable at each rising edge. It keeps all controls at defined levels from time zero. To exercise the pause and priority properties, it inserts idle cycles with `shift_en` low in the middle of additions. It also asserts `load` together with `shift_en`.

// File: rtl/bsa_pkg.sv
// Package: shared action code for the bit-serial adder.
// Assumes: consumers decode exactly the three values below.
package bsa_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,   // hold all state
        ACT_LOAD = 2'd1,   // parallel load, clear carry
        ACT_STEP = 2'd2    // one serial addition step
    } bsa_act_e;
endpackage

// File: rtl/bsa_full_adder.sv
// Module: one-bit full adder cell used once per serial step.
// Assumes: purely combinational, inputs are known.
module bsa_full_adder (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);
    // Sum and majority carry of three input bits.
    always_comb begin
        s_bit = a_bit ^ b_bit ^ c_in;
        c_out = (a_bit & b_bit) | (a_bit & c_in) | (b_bit & c_in);
    end
endmodule

// File: rtl/bsa_shift_reg.sv
// Module: right-shifting register with parallel load and serial top input.
// Assumes: act is ACT_LOAD, ACT_STEP or ACT_IDLE; reset is synchronous, active low.
module bsa_shift_reg
    import bsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bsa_act_e         act,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q,
    output logic             lsb
);
    logic [WIDTH-1:0] q_r;

    // Register update: reset, load, shift right, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_r <= '0;
        else if (act == ACT_LOAD)
            q_r <= par_in;
        else if (act == ACT_STEP)
            q_r <= {ser_in, q_r[WIDTH-1:1]};
    end

    assign q   = q_r;
    assign lsb = q_r[0];

    // R4 / R3: the serial input lands in the top bit on a step.
    a_r4_ser_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP) |=> (q_r[WIDTH-1] == $past(ser_in)));
    // R5: idle action keeps the register unchanged.
    a_r5_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IDLE) |=> $stable(q_r));
    // R2: a load writes the parallel input.
    a_r2_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LOAD) |=> (q_r == $past(par_in)));
endmodule

// File: rtl/bsa_seq_ctrl.sv
// Module: step sequencer; counts enabled steps and raises done after WIDTH.
// Assumes: load and shift_en known each edge; load wins over shift_en.
module bsa_seq_ctrl
    import bsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic     shift_en,
    output bsa_act_e act,
    output logic     done
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [CW-1:0] step_cnt;
    logic          done_r;

    // Decode the action for this cycle with load priority and auto-stop.
    always_comb begin
        if (load)
            act = ACT_LOAD;
        else if (shift_en && !done_r)
            act = ACT_STEP;
        else
            act = ACT_IDLE;
    end

    // Step counter and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
            done_r   <= 1'b0;
        end else if (act == ACT_LOAD) begin
            step_cnt <= '0;
            done_r   <= 1'b0;
        end else if (act == ACT_STEP) begin
            step_cnt <= step_cnt + 1'b1;
            if (step_cnt == LAST)
                done_r <= 1'b1;
        end
    end

    assign done = done_r;

    // R7: done stays high until the next load.
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_r && !load) |=> done_r);
    // R2: load clears done.
    a_r2_load_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done_r);
    // R6: done only rises on a step.
    a_r6_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_r) |-> ($past(act) == ACT_STEP));
endmodule

// File: rtl/bitser_adder.sv
// Module: bit-serial adder top; two shift registers, one full adder, a carry bit.
// Assumes: a single load pulse starts each addition; shift_en gates progress.
module bitser_adder
    import bsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] opa_in,
    input  logic [WIDTH-1:0] opb_in,
    input  logic             b_ser_in,
    output logic [WIDTH-1:0] sum_out,
    output logic [WIDTH-1:0] b_out,
    output logic             carry_out,
    output logic             done
);
    bsa_act_e act;
    logic     a_lsb, b_lsb;
    logic     fa_sum, fa_cout;
    logic     carry_q;

    bsa_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .act      (act),
        .done     (done)
    );

    bsa_full_adder u_fa (
        .a_bit (a_lsb),
        .b_bit (b_lsb),
        .c_in  (carry_q),
        .s_bit (fa_sum),
        .c_out (fa_cout)
    );

    bsa_shift_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .par_in (opa_in),
        .ser_in (fa_sum),
        .q      (sum_out),
        .lsb    (a_lsb)
    );

    bsa_shift_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .par_in (opb_in),
        .ser_in (b_ser_in),
        .q      (b_out),
        .lsb    (b_lsb)
    );

    // Carry flip-flop: cleared on load, updated on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (act == ACT_LOAD)
            carry_q <= 1'b0;
        else if (act == ACT_STEP)
            carry_q <= fa_cout;
    end

    assign carry_out = carry_q;

    // R5: no load and no enable keeps the carry.
    a_r5_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_en) |=> $stable(carry_q));
    // R7: once done, the result is frozen until a load.
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> ($stable(sum_out) && $stable(b_out) && $stable(carry_q)));
    // R2: load clears the carry.
    a_r2_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !carry_q);
endmodule

// File: tb/bitser_adder_bench.sv
module bitser_adder_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         shift_en = 1'b0;
    logic [W-1:0] opa_in = '0;
    logic [W-1:0] opb_in = '0;
    logic         b_ser_in = 1'b0;
    logic [W-1:0] sum_out, b_out;
    logic         carry_out, done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bitser_adder #(.WIDTH(W)) u_bitser_adder (
        .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
        .opa_in(opa_in), .opb_in(opb_in), .b_ser_in(b_ser_in),
        .sum_out(sum_out), .b_out(b_out), .carry_out(carry_out), .done(done)
    );

    task automatic chk(string tag, longint act_v, longint exp_v);
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    function automatic longint mk(int k);
        return (longint'(1) << k) - 1;
    endfunction

    // Model of A after k steps.
    function automatic longint exp_a(longint a, longint b, int k);
        longint s;
        s = ((a & mk(k)) + (b & mk(k))) & mk(k);
        return ((s << (W - k)) | (a >> k)) & mk(W);
    endfunction

    function automatic longint exp_c(longint a, longint b, int k);
        return (((a & mk(k)) + (b & mk(k))) >> k) & 1;
    endfunction

    function automatic longint exp_b(longint b, longint sin, int k);
        return ((b >> k) | ((sin & mk(k)) << (W - k))) & mk(W);
    endfunction

    // Load operands with a one-cycle pulse; continue at a falling edge.
    task automatic do_load(logic [W-1:0] a, logic [W-1:0] b, logic en);
        @(negedge clk);
        load = 1'b1; opa_in = a; opb_in = b; shift_en = en;
        @(negedge clk);
        load = 1'b0; shift_en = 1'b0;
        chk("R2 load A", sum_out, a);
        chk("R2 load B", b_out, b);
        chk("R2 carry clear", carry_out, 0);
        chk("R2 done clear", done, 0);
    endtask

    // Full addition with optional pauses and a serial word into B.
    task automatic t_add(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] sin, bit gaps);
        int k = 0;
        do_load(a, b, 1'b0);
        for (int i = 0; k < W; i++) begin
            logic en;
            logic [W-1:0] pa, pb;
            logic pc;
            en = gaps ? (i % 3 != 2) : 1'b1;
            pa = sum_out; pb = b_out; pc = carry_out;
            shift_en = en;
            b_ser_in = sin[k];
            @(negedge clk);
            if (en) begin
                k++;
                chk("R3 partial A", sum_out, exp_a(a, b, k));
                chk("R3 carry", carry_out, exp_c(a, b, k));
                chk("R4 B shift", b_out, exp_b(b, sin, k));
            end else begin
                chk("R5 hold A", sum_out, pa);
                chk("R5 hold B", b_out, pb);
                chk("R5 hold carry", carry_out, pc);
                chk("R5 hold done", done, 0);
            end
        end
        shift_en = 1'b0;
        chk("R6 sum", sum_out, (longint'(a) + longint'(b)) & mk(W));
        chk("R6 carry", carry_out, ((longint'(a) + longint'(b)) >> W) & 1);
        chk("R6 done", done, 1);
        chk("R8 new operand in B", b_out, sin);
        // Keep enabling: nothing may move.
        shift_en = 1'b1; b_ser_in = ~b_ser_in;
        repeat (3) @(negedge clk);
        shift_en = 1'b0;
        chk("R7 frozen sum", sum_out, (longint'(a) + longint'(b)) & mk(W));
        chk("R7 frozen B", b_out, sin);
        chk("R7 frozen carry", carry_out, ((longint'(a) + longint'(b)) >> W) & 1);
        chk("R7 done held", done, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset A", sum_out, 0);
        chk("R1 reset B", b_out, 0);
        chk("R1 reset carry", carry_out, 0);
        chk("R1 reset done", done, 0);
        rst_n = 1'b1;
    endtask

    // Load together with shift_en: load must win.
    task automatic t_load_priority();
        do_load(8'h3C, 8'hA5, 1'b1);
    endtask

    // Reload in the middle of an addition restarts the count.
    task automatic t_midrun_reload();
        do_load(8'hFF, 8'hFF, 1'b0);
        shift_en = 1'b1;
        repeat (3) @(negedge clk);
        shift_en = 1'b0;
        chk("R2 mid-run not done", done, 0);
        t_add(8'h81, 8'h7F, 8'h00, 1'b0);
    endtask

    initial begin
        t_reset();
        t_add(8'h0B, 8'h05, 8'hC3, 1'b0);
        t_add(8'hFF, 8'h01, 8'h5A, 1'b1);
        t_add(8'hA7, 8'h6E, 8'hFF, 1'b1);
        t_add(8'h00, 8'h00, 8'h01, 1'b0);
        t_load_priority();
        t_midrun_reload();
        t_add(8'hF0, 8'hF0, 8'h96, 1'b1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule